// File: doc/BRIEF.md
# Block-Transfer Command Queue with Group Completion

This block sits between a processor core and the bus side of a local scratchpad. The core hands it block-transfer commands, each naming a direction (external to local, or local to external), a local address, an external address, a byte count and a 5-bit group tag. Up to 16 accepted commands wait in the queue. The oldest command is cut into line requests of at most 128 bytes. Each line request is presented to the bus/memory side with a valid/ready handshake. The external address goes out unchanged, because address translation is modelled here as a pass-through.

For every group tag the block keeps a count of outstanding commands. It exposes a 32-bit mask in which a bit is high when no accepted, unfinished command carries that tag. Software writes a query mask. The interrupt output is high whenever every group selected by that mask is complete. A command with a misaligned address or an illegal size is flagged for one cycle and thrown away.

Top module: `xfer_queue`

## Requirements
- R1: `cmd_ready` is low exactly when 16 accepted commands are outstanding. A command offered while `cmd_ready` is low is neither accepted nor flagged, and has no effect.
- R2: Commands are served strictly in the order they were accepted. While any command is outstanding, `line_valid` is high, and `line_tag` and `line_put` carry the oldest command's tag and direction (1 = local to external, 0 = external to local).
- R3: A command's lines start at its own local and external addresses. Each following line sits 128 bytes higher in both address spaces. The external address is passed through with no translation applied.
- R4: `line_bytes` is 128 for every line except the final one. The final line carries the bytes that remain (16 to 128), with `line_last` high. `line_beats` is `line_bytes`/8.
- R5: A command offered while `cmd_ready` is high is rejected when any of these holds: local or external address bits [3:0] are nonzero, size bits [3:0] are nonzero, size is 0, or size exceeds 16384. On rejection `cmd_bad` is high in that same cycle, and the command is dropped without touching the queue or the group state.
- R6: Bit g of `grp_done` is 1 exactly when no outstanding command has tag g. A command counts as outstanding from the cycle after its acceptance until the cycle after its last line handshake.
- R7: `irq` is high exactly when `query_mask` is nonzero and every bit set in `query_mask` is also set in `grp_done`.
- R8: While `line_valid` is high and `line_ready` is low, all line outputs hold their values into the next cycle.
- R9: During and right after reset: `line_valid` is low, `cmd_ready` is high, `grp_done` is all ones, and `irq` is low while `query_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_put | input | 1 | 1 = local to external, 0 = external to local |
| cmd_laddr | input | 18 | Local start address |
| cmd_eaddr | input | 32 | External start address |
| cmd_size | input | 15 | Byte count |
| cmd_tag | input | 5 | Group tag |
| cmd_bad | output | 1 | Offered command rejected this cycle |
| line_valid | output | 1 | Line request pending |
| line_ready | input | 1 | Bus side takes the line request |
| line_put | output | 1 | Direction of the line |
| line_laddr | output | 18 | Local address of the line |
| line_eaddr | output | 32 | External address of the line |
| line_bytes | output | 8 | Bytes in this line |
| line_beats | output | 5 | 8-byte bus beats in this line |
| line_last | output | 1 | Final line of its command |
| line_tag | output | 5 | Group tag of the line's command |
| grp_done | output | 32 | Per-group completion mask |
| query_mask | input | 32 | Groups the interrupt waits for |
| irq | output | 1 | All queried groups complete |

## Verification
The hardest situation to reach from the ports is a full queue that also has a seventeenth command waiting at its input. To get there, the bench holds `line_ready` low while it fills all 16 slots. The first slot holds a 16384-byte command, so the stall later unwinds through 128 lines. The bench offers the extra command for several cycles and then releases the bus. This makes a retirement and a new acceptance land in the same cycle. A long random phase with few tags then often retires and enqueues the same group in one cycle, which exercises the counter for a tag that is incremented and decremented at once.

// File: rtl/xq_pkg.sv
package xq_pkg;
    parameter int LADDR_W = 18;
    parameter int EADDR_W = 32;
    parameter int SIZE_W  = 15;
    parameter int TAG_W   = 5;

    typedef struct packed {
        logic               put;
        logic [LADDR_W-1:0] laddr;
        logic [EADDR_W-1:0] eaddr;
        logic [SIZE_W-1:0]  size;
        logic [TAG_W-1:0]   tag;
    } xfer_cmd_t;
endpackage

// File: rtl/xq_cmd_fifo.sv
module xq_cmd_fifo import xq_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  xfer_cmd_t        push_data,
    input  logic             pop,
    output xfer_cmd_t        head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        xfer_cmd_t [DEPTH-1:0] mem;
        logic [PTR_W:0]        wr;
        logic [PTR_W:0]        rd;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    assign count = st_q.wr - st_q.rd;
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = st_q.mem[st_q.rd[PTR_W-1:0]];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr[PTR_W-1:0]] = push_data;
            st_d.wr = st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xq_line_splitter.sv
module xq_line_splitter import xq_pkg::*; #(
    parameter int LINE_BYTES = 128,
    parameter int BEAT_BYTES = 8,
    localparam int LINE_W  = $clog2(LINE_BYTES) + 1,
    localparam int BEAT_W  = $clog2(LINE_BYTES / BEAT_BYTES) + 1,
    localparam int BEAT_SH = $clog2(BEAT_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               has_cmd,
    input  xfer_cmd_t          head,
    input  logic               line_ready,
    output logic               line_valid,
    output logic [LADDR_W-1:0] line_laddr,
    output logic [EADDR_W-1:0] line_eaddr,
    output logic [LINE_W-1:0]  line_bytes,
    output logic [BEAT_W-1:0]  line_beats,
    output logic               line_last,
    output logic               cmd_done
);
    typedef struct packed {
        logic [SIZE_W-1:0] off;
    } split_st_t;

    split_st_t st_d, st_q;
    logic [SIZE_W-1:0] remaining;
    logic              fire;

    always_comb begin
        remaining  = head.size - st_q.off;
        line_last  = (remaining <= SIZE_W'(LINE_BYTES));
        line_bytes = line_last ? remaining[LINE_W-1:0] : LINE_W'(LINE_BYTES);
        line_beats = BEAT_W'(line_bytes >> BEAT_SH);
        line_laddr = head.laddr + LADDR_W'(st_q.off);
        line_eaddr = head.eaddr + EADDR_W'(st_q.off);
        line_valid = has_cmd;
        fire       = has_cmd && line_ready;
        cmd_done   = fire && line_last;

        st_d = st_q;
        if (fire) begin
            st_d.off = line_last ? '0 : st_q.off + SIZE_W'(LINE_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xq_group_tracker.sv
module xq_group_tracker #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 5,
    localparam int NGRP  = 1 << TAG_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [TAG_W-1:0] inc_tag,
    input  logic             dec,
    input  logic [TAG_W-1:0] dec_tag,
    output logic [NGRP-1:0]  grp_done
);
    typedef struct packed {
        logic [NGRP-1:0][CNT_W-1:0] cnt;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NGRP; g++) begin
            if (inc && inc_tag == TAG_W'(g)) st_d.cnt[g] = st_d.cnt[g] + CNT_W'(1);
            if (dec && dec_tag == TAG_W'(g)) st_d.cnt[g] = st_d.cnt[g] - CNT_W'(1);
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_done
        assign grp_done[g] = (st_q.cnt[g] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xfer_queue.sv
module xfer_queue import xq_pkg::*; #(
    parameter int DEPTH       = 16,
    parameter int LINE_BYTES  = 128,
    parameter int BEAT_BYTES  = 8,
    parameter int ALIGN_BYTES = 16,
    parameter int MAX_BYTES   = 16384,
    localparam int NGRP   = 1 << TAG_W,
    localparam int LINE_W = $clog2(LINE_BYTES) + 1,
    localparam int BEAT_W = $clog2(LINE_BYTES / BEAT_BYTES) + 1,
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int AL_W   = $clog2(ALIGN_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_put,
    input  logic [LADDR_W-1:0] cmd_laddr,
    input  logic [EADDR_W-1:0] cmd_eaddr,
    input  logic [SIZE_W-1:0]  cmd_size,
    input  logic [TAG_W-1:0]   cmd_tag,
    output logic               cmd_bad,
    output logic               line_valid,
    input  logic               line_ready,
    output logic               line_put,
    output logic [LADDR_W-1:0] line_laddr,
    output logic [EADDR_W-1:0] line_eaddr,
    output logic [LINE_W-1:0]  line_bytes,
    output logic [BEAT_W-1:0]  line_beats,
    output logic               line_last,
    output logic [TAG_W-1:0]   line_tag,
    output logic [NGRP-1:0]    grp_done,
    input  logic [NGRP-1:0]    query_mask,
    output logic               irq
);
    xfer_cmd_t        in_cmd, head;
    logic             fifo_empty, fifo_full, accept, illegal, cmd_done;
    logic [CNT_W-1:0] q_count;

    always_comb begin
        in_cmd  = '{put: cmd_put, laddr: cmd_laddr, eaddr: cmd_eaddr,
                    size: cmd_size, tag: cmd_tag};
        illegal = (cmd_laddr[AL_W-1:0] != '0) || (cmd_eaddr[AL_W-1:0] != '0) ||
                  (cmd_size[AL_W-1:0] != '0)  || (cmd_size == '0) ||
                  (cmd_size > SIZE_W'(MAX_BYTES));
        cmd_ready = !fifo_full;
        accept    = cmd_valid && cmd_ready && !illegal;
        cmd_bad   = cmd_valid && cmd_ready && illegal;
        line_put  = head.put;
        line_tag  = head.tag;
        irq       = (query_mask != '0) && ((query_mask & ~grp_done) == '0);
    end

    xq_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_data(in_cmd),
        .pop(cmd_done), .head(head), .empty(fifo_empty), .full(fifo_full),
        .count(q_count)
    );

    xq_line_splitter #(.LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_split (
        .clk(clk), .rst_n(rst_n), .has_cmd(!fifo_empty), .head(head),
        .line_ready(line_ready), .line_valid(line_valid), .line_laddr(line_laddr),
        .line_eaddr(line_eaddr), .line_bytes(line_bytes), .line_beats(line_beats),
        .line_last(line_last), .cmd_done(cmd_done)
    );

    xq_group_tracker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_track (
        .clk(clk), .rst_n(rst_n), .inc(accept), .inc_tag(cmd_tag),
        .dec(cmd_done), .dec_tag(head.tag), .grp_done(grp_done)
    );
endmodule

// File: rtl/xq_checker.sv
module xq_checker #(
    parameter int DEPTH       = 16,
    parameter int LINE_BYTES  = 128,
    parameter int ALIGN_BYTES = 16,
    parameter int LADDR_W     = 18,
    parameter int EADDR_W     = 32,
    parameter int TAG_W       = 5,
    localparam int NGRP   = 1 << TAG_W,
    localparam int LINE_W = $clog2(LINE_BYTES) + 1,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_ready,
    input logic               cmd_bad,
    input logic               line_valid,
    input logic               line_ready,
    input logic [LADDR_W-1:0] line_laddr,
    input logic [EADDR_W-1:0] line_eaddr,
    input logic [LINE_W-1:0]  line_bytes,
    input logic               line_last,
    input logic [TAG_W-1:0]   line_tag,
    input logic [NGRP-1:0]    grp_done,
    input logic [CNT_W-1:0]   q_count
);
    logic retire;
    assign retire = line_valid && line_ready && line_last;

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !retire) |=> (q_count == $past(q_count)));

    // R5
    bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_bad && !retire) |=> $stable(q_count));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_ready && !line_last) |=>
        (line_valid && line_laddr == $past(line_laddr) + LADDR_W'(LINE_BYTES) &&
         line_eaddr == $past(line_eaddr) + EADDR_W'(LINE_BYTES)));

    // R4
    line_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_bytes != '0 && line_bytes <= LINE_W'(LINE_BYTES) &&
                        (line_bytes & LINE_W'(ALIGN_BYTES - 1)) == '0));

    // R6
    busy_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !grp_done[line_tag]);

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready) |=>
        (line_valid && $stable(line_laddr) && $stable(line_eaddr) &&
         $stable(line_bytes) && $stable(line_tag)));
endmodule

bind xfer_queue xq_checker #(
    .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .ALIGN_BYTES(ALIGN_BYTES),
    .LADDR_W(xq_pkg::LADDR_W), .EADDR_W(xq_pkg::EADDR_W), .TAG_W(xq_pkg::TAG_W)
) u_xq_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_bad(cmd_bad),
    .line_valid(line_valid), .line_ready(line_ready), .line_laddr(line_laddr),
    .line_eaddr(line_eaddr), .line_bytes(line_bytes), .line_last(line_last),
    .line_tag(line_tag), .grp_done(grp_done), .q_count(q_count)
);

// File: tb/test_xfer_queue.sv
module test_xfer_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_put, line_ready;
    logic [17:0] cmd_laddr;
    logic [31:0] cmd_eaddr, query_mask;
    logic [14:0] cmd_size;
    logic [4:0]  cmd_tag;
    logic        cmd_ready, cmd_bad, line_valid, line_put, line_last, irq;
    logic [17:0] line_laddr;
    logic [31:0] line_eaddr, grp_done;
    logic [7:0]  line_bytes;
    logic [4:0]  line_beats, line_tag;

    always #4 clk = ~clk;

    xfer_queue i_xfer_queue (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_put(cmd_put), .cmd_laddr(cmd_laddr), .cmd_eaddr(cmd_eaddr),
        .cmd_size(cmd_size), .cmd_tag(cmd_tag), .cmd_bad(cmd_bad),
        .line_valid(line_valid), .line_ready(line_ready), .line_put(line_put),
        .line_laddr(line_laddr), .line_eaddr(line_eaddr), .line_bytes(line_bytes),
        .line_beats(line_beats), .line_last(line_last), .line_tag(line_tag),
        .grp_done(grp_done), .query_mask(query_mask), .irq(irq)
    );

    typedef struct {
        bit     put;
        int     la;
        longint ea;
        int     sz;
        int     tag;
    } mc_t;

    mc_t mq[$];
    int  off;
    int  gcnt[32];
    int  checks, fails;
    bit  last_ready, stalled, finished;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit offered_bad();
        return (cmd_laddr[3:0] != 0) || (cmd_eaddr[3:0] != 0) || (cmd_size[3:0] != 0) ||
               (cmd_size == 0) || (cmd_size > 15'd16384);
    endfunction

    // One clock: inputs are already set after a falling edge.
    task automatic cyc();
        bit    e_ready, e_bad, e_valid, e_last;
        int    rem, e_bytes;
        logic [31:0] e_done;
        bit    e_irq;
        string rq;
        mc_t   c;
        #1;
        e_ready = mq.size() < 16;
        e_bad   = cmd_valid && e_ready && offered_bad();
        chk("R1", "cmd_ready", cmd_ready, e_ready);
        chk("R5", "cmd_bad", cmd_bad, e_bad);
        e_valid = mq.size() != 0;
        chk("R2", "line_valid", line_valid, e_valid);
        e_last = 0;
        if (e_valid) begin
            rem     = mq[0].sz - off;
            e_last  = rem <= 128;
            e_bytes = e_last ? rem : 128;
            rq      = stalled ? "R8" : "R3";
            chk("R2", "line_tag", line_tag, mq[0].tag);
            chk("R2", "line_put", line_put, mq[0].put);
            chk(rq, "line_laddr", line_laddr, (mq[0].la + off) & 'h3ffff);
            chk(rq, "line_eaddr", line_eaddr, (mq[0].ea + off) & 64'hffffffff);
            chk("R4", "line_bytes", line_bytes, e_bytes);
            chk("R4", "line_beats", line_beats, e_bytes / 8);
            chk("R4", "line_last", line_last, e_last);
        end
        for (int g = 0; g < 32; g++) e_done[g] = (gcnt[g] == 0);
        chk("R6", "grp_done", grp_done, e_done);
        e_irq = (query_mask != 0) && ((query_mask & ~e_done) == 0);
        chk("R7", "irq", irq, e_irq);

        stalled = e_valid && !line_ready;
        if (e_valid && line_ready) begin
            if (e_last) begin
                gcnt[mq[0].tag]--;
                void'(mq.pop_front());
                off = 0;
            end else begin
                off += 128;
            end
        end
        if (cmd_valid && e_ready && !e_bad) begin
            c.put = cmd_put; c.la = cmd_laddr; c.ea = cmd_eaddr;
            c.sz = cmd_size; c.tag = cmd_tag;
            mq.push_back(c);
            gcnt[cmd_tag]++;
        end
        last_ready = e_ready;
        @(negedge clk);
    endtask

    task automatic send(bit put, int la, longint ea, int sz, int tag);
        cmd_valid = 1; cmd_put = put; cmd_laddr = la[17:0]; cmd_eaddr = ea[31:0];
        cmd_size = sz[14:0]; cmd_tag = tag[4:0];
        for (int k = 0; k < 400; k++) begin
            cyc();
            if (last_ready) break;
        end
        cmd_valid = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 5000 && mq.size() != 0; k++) cyc();
        cyc();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_put = 0; cmd_laddr = 0; cmd_eaddr = 0;
        cmd_size = 0; cmd_tag = 0; line_ready = 0; query_mask = 0;
        off = 0; stalled = 0;
        for (int g = 0; g < 32; g++) gcnt[g] = 0;
        #22;
        // R9: reset state
        chk("R9", "line_valid", line_valid, 0);
        chk("R9", "cmd_ready", cmd_ready, 1);
        chk("R9", "grp_done", grp_done, 32'hffffffff);
        chk("R9", "irq", irq, 0);
        @(negedge clk);
        rst_n = 1;
        cyc(); cyc();

        // single short line
        line_ready = 1;
        send(0, 'h100, 64'h80000000, 16, 3);
        cyc(); cyc(); cyc();

        // multi-line put with partial last line and a stalling bus
        query_mask = 32'h80;
        send(1, 'h2000, 64'h12345670, 400, 7);
        for (int i = 0; i < 14; i++) begin
            line_ready = (i % 3) != 0;
            cyc();
        end
        line_ready = 1;
        drain();

        // rejected commands
        send(0, 'h108, 64'h1000, 32, 1);
        send(0, 'h100, 64'h1004, 32, 1);
        send(0, 'h100, 64'h1000, 24, 1);
        send(0, 'h100, 64'h1000, 0, 1);
        send(0, 'h100, 64'h1000, 16400, 1);
        cyc();

        // fill the queue with the bus stalled, then offer one more
        line_ready = 0;
        query_mask = 32'h0f;
        send(1, 'h3fff0, 64'hfffffff0, 16384, 0);
        for (int i = 1; i < 16; i++) send(i % 2, i * 'h400, 64'h40000000 + i * 'h1000, 16 * (i + 1), i % 4);
        cmd_valid = 1; cmd_put = 0; cmd_laddr = 'h500; cmd_eaddr = 'h7700;
        cmd_size = 48; cmd_tag = 2;
        cyc(); cyc(); cyc();
        cmd_laddr = 'h501;
        cyc();
        cmd_laddr = 'h500;
        line_ready = 1;
        for (int k = 0; k < 400 && !last_ready; k++) cyc();
        cmd_valid = 0;
        drain();

        // random traffic on few tags
        for (int i = 0; i < 4000; i++) begin
            cmd_valid  = ($urandom % 3) == 0;
            cmd_put    = $urandom % 2;
            cmd_laddr  = 18'(($urandom % 4096) * 16 + (($urandom % 20) == 0 ? 4 : 0));
            cmd_eaddr  = ($urandom % 65536) * 16;
            cmd_size   = 15'(($urandom % 40) * 16);
            cmd_tag    = 5'($urandom % 4);
            line_ready = ($urandom % 4) != 0;
            if (($urandom % 50) == 0) query_mask = $urandom % 16;
            cyc();
        end
        cmd_valid = 0;
        line_ready = 1;
        drain();
        finish_run();
    end
endmodule